// File: doc/BRIEF.md
# Bulk-Erase Flash Command Controller

This block models a byte-wide flash memory with whole-array erase, attached to a plain synchronous read/write bus. Bytes written on the bus are decoded as commands by a small state machine. The commands select one of several modes. In read-array mode, reads return stored bytes. In identifier mode, reads return fixed code bytes. Two-step erase and program sequences each finish with a verify mode, in which reads return the byte at a latched address. Stored bits can only be cleared by programming. Only the erase sequence sets them back to one, and it does so for the whole array at once.

The bus has no back-pressure. A write is taken on every rising clock edge where `wr_en` is high. A read is taken on every rising edge where `rd_en` is high, and its result appears on `rdata` after that edge. No write changes anything unless `vpp_en` is high. The storage depth is a power-of-two parameter, and bus addresses are folded onto it by dropping the upper bits. The identifier codes and the value returned for undefined reads are parameters.

Top module: `bulk_flash_ctrl`

## Requirements
- R1: After reset the block is in read-array mode, `rdata` is 0x00, `cmd_err` is low and every stored byte reads 0xFF.
- R2: While `vpp_en` is low, a bus write changes neither the mode nor the stored data, and it does not raise `cmd_err`.
- R3: Writing 0x20 starts erase setup. A second 0x20 sets every stored byte to 0xFF and enters the erased mode. Writing 0xFF during erase setup returns to read-array mode and leaves the contents unchanged.
- R4: In the erased mode, writing 0xA0 latches the folded write address and enters erase verify. Reads then return the byte at the latched address, whatever the read address is.
- R5: Writing 0x40 starts program setup. The next write stores (old byte AND write data) at its folded address, latches that address and enters the program mode.
- R6: In the program mode, writing 0xC0 enters program verify, where reads return the byte at the latched address. Writing 0xFF returns to read-array mode.
- R7: Writing 0x90, or the alternate code 0x80, enters identifier mode. A read at full bus address 0 returns MFG_CODE (0x89 by default). Address 1 returns DEV_CODE (0xB4 by default). Any other address, including ones that fold onto 0 or 1, returns OPEN_BUS (0x00 by default).
- R8: Read-array reads and program writes use the bus address folded to the storage depth, that is, its low log2(DEPTH) bits.
- R9: In read-array, identifier, erase-verify and program-verify modes, a write starts a new operation. The byte 0x00 or 0xFF gives read-array, 0x90 or 0x80 gives identifier, 0x20 gives erase setup, and 0x40 gives program setup. A direct 0xA0 latches the folded address and enters erase verify.
- R10: A command byte that the current mode does not accept leaves the mode unchanged and raises `cmd_err` for exactly the one cycle after the write edge. For example, 0xC0 is rejected in read-array mode, and any byte other than 0xA0 is rejected in the erased mode.
- R11: Reads taken during erase setup, the erased mode, program setup or the program mode return OPEN_BUS.
- R12: `rdata` changes only after an edge with `rd_en` high, and it holds its value otherwise. When a read and a write share an edge, the read sees the mode and contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Bus byte address |
| wdata | input | 8 | Write data or command byte |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| rd_en | input | 1 | Read strobe, sampled at the clock edge |
| vpp_en | input | 1 | Program-power enable; writes are ignored while low |
| rdata | output | 8 | Registered read data, one cycle after `rd_en` |
| cmd_err | output | 1 | One-cycle pulse for each rejected command byte |

## Verification
The two functions that can fall in the same cycle are a read and a command or program write, because both strobes can be high on the same edge. The bench provokes this in two ways. It issues a read together with an identifier command in read-array mode, and it issues a read together with a program data write. In both cases it judges that `rdata` carries the pre-write view: the array byte rather than the identifier code, or OPEN_BUS from program setup. It then checks that a following read shows the new mode or the new contents.

// File: rtl/bulk_flash_pkg.sv
package bulk_flash_pkg;

  typedef enum logic [2:0] {
    ST_READ      = 3'd0,
    ST_IDENT     = 3'd1,
    ST_ERS_SETUP = 3'd2,
    ST_ERASED    = 3'd3,
    ST_ERS_VFY   = 3'd4,
    ST_PGM_SETUP = 3'd5,
    ST_PGM       = 3'd6,
    ST_PGM_VFY   = 3'd7
  } fstate_e;

  localparam logic [7:0] OP_READ      = 8'h00;
  localparam logic [7:0] OP_ERASE     = 8'h20;
  localparam logic [7:0] OP_PROGRAM   = 8'h40;
  localparam logic [7:0] OP_IDENT_ALT = 8'h80;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_ERS_VFY   = 8'hA0;
  localparam logic [7:0] OP_PGM_VFY   = 8'hC0;
  localparam logic [7:0] OP_RESET     = 8'hFF;

endpackage

// File: rtl/bulk_flash_fsm.sv
module bulk_flash_fsm
  import bulk_flash_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             vpp_en,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] wr_idx,
  output fstate_e          state_q,
  output logic [IDX_W-1:0] latch_idx_q,
  output logic             erase_all,
  output logic             prog_we,
  output logic             cmd_err_q
);

  fstate_e state_d;
  logic    latch_now;
  logic    reject;
  logic    take;

  assign take = wr_en && vpp_en;

  always_comb begin
    state_d   = state_q;
    erase_all = 1'b0;
    prog_we   = 1'b0;
    latch_now = 1'b0;
    reject    = 1'b0;
    if (take) begin
      unique case (state_q)
        ST_ERS_SETUP: begin
          if (wdata == OP_ERASE) begin
            erase_all = 1'b1;
            state_d   = ST_ERASED;
          end else if (wdata == OP_RESET) begin
            state_d = ST_READ;
          end else begin
            reject = 1'b1;
          end
        end
        ST_ERASED: begin
          if (wdata == OP_ERS_VFY) begin
            latch_now = 1'b1;
            state_d   = ST_ERS_VFY;
          end else begin
            reject = 1'b1;
          end
        end
        ST_PGM_SETUP: begin
          prog_we   = 1'b1;
          latch_now = 1'b1;
          state_d   = ST_PGM;
        end
        ST_PGM: begin
          if (wdata == OP_PGM_VFY) begin
            state_d = ST_PGM_VFY;
          end else if (wdata == OP_RESET) begin
            state_d = ST_READ;
          end else begin
            reject = 1'b1;
          end
        end
        default: begin
          unique case (wdata)
            OP_READ, OP_RESET:     state_d = ST_READ;
            OP_IDENT, OP_IDENT_ALT: state_d = ST_IDENT;
            OP_ERASE:              state_d = ST_ERS_SETUP;
            OP_PROGRAM:            state_d = ST_PGM_SETUP;
            OP_ERS_VFY: begin
              latch_now = 1'b1;
              state_d   = ST_ERS_VFY;
            end
            default:               reject = 1'b1;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_READ;
      latch_idx_q <= '0;
      cmd_err_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      cmd_err_q <= reject;
      if (latch_now) latch_idx_q <= wr_idx;
    end
  end

  // R2: an unpowered write leaves the mode alone and flags nothing
  assert_unpowered_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !vpp_en) |=> ($stable(state_q) && !cmd_err_q));

  // R10: a rejected byte leaves the mode where it was
  assert_reject_holds_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err_q |-> $stable(state_q));

  // R4 / R9: entering erase verify always captures the written address
  assert_verify_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && state_d == ST_ERS_VFY && state_q != ST_ERS_VFY) |=> (latch_idx_q == $past(wr_idx)));

endmodule

// File: rtl/bulk_flash_array.sv
module bulk_flash_array #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase_all,
  input  logic             prog_we,
  input  logic [IDX_W-1:0] prog_idx,
  input  logic [7:0]       prog_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte
);

  logic [7:0] mem_q [DEPTH];
  logic [7:0] prog_old;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[i] <= 8'hFF;
      end else if (erase_all) begin
        mem_q[i] <= 8'hFF;
      end else if (prog_we && prog_idx == IDX_W'(i)) begin
        mem_q[i] <= mem_q[i] & prog_data;
      end
    end
  end

  assign rd_byte  = mem_q[rd_idx];
  assign prog_old = mem_q[prog_idx];

  // R5: programming never sets a bit that was clear
  assert_prog_clears_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> ((mem_q[$past(prog_idx)] & ~$past(prog_old)) == 8'h00));

  // R3: a bulk erase leaves both ends of the array at all ones
  assert_erase_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_all |=> (mem_q[0] == 8'hFF && mem_q[DEPTH-1] == 8'hFF));

endmodule

// File: rtl/bulk_flash_rdmux.sv
module bulk_flash_rdmux
  import bulk_flash_pkg::*;
#(
  parameter int         ADDR_W   = 12,
  parameter logic [7:0] MFG_CODE = 8'h89,
  parameter logic [7:0] DEV_CODE = 8'hB4,
  parameter logic [7:0] OPEN_BUS = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  fstate_e           state_q,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        arr_byte,
  output logic [7:0]        rdata_q
);

  logic [7:0] sel;

  always_comb begin
    unique case (state_q)
      ST_READ, ST_ERS_VFY, ST_PGM_VFY: sel = arr_byte;
      ST_IDENT: begin
        if (addr == ADDR_W'(0))      sel = MFG_CODE;
        else if (addr == ADDR_W'(1)) sel = DEV_CODE;
        else                         sel = OPEN_BUS;
      end
      default: sel = OPEN_BUS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= 8'h00;
    else if (rd_en) rdata_q <= sel;
  end

  // R12: read data moves only on a read edge
  assert_rdata_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));

  // R11: reads inside an unfinished sequence see the open-bus value
  assert_open_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (state_q == ST_ERS_SETUP || state_q == ST_ERASED ||
               state_q == ST_PGM_SETUP || state_q == ST_PGM)) |=> (rdata_q == OPEN_BUS));

endmodule

// File: rtl/bulk_flash_ctrl.sv
module bulk_flash_ctrl
  import bulk_flash_pkg::*;
#(
  parameter int         ADDR_W   = 12,
  parameter int         DEPTH    = 64,
  parameter logic [7:0] MFG_CODE = 8'h89,
  parameter logic [7:0] DEV_CODE = 8'hB4,
  parameter logic [7:0] OPEN_BUS = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              vpp_en,
  output logic [7:0]        rdata,
  output logic              cmd_err
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  initial begin
    if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2)
      $error("DEPTH must be a power of two of at least 2");
    if (ADDR_W < IDX_W)
      $error("ADDR_W too narrow for DEPTH");
  end

  fstate_e          state_q;
  logic [IDX_W-1:0] latch_idx_q;
  logic [IDX_W-1:0] bus_idx;
  logic [IDX_W-1:0] rd_idx;
  logic             erase_all;
  logic             prog_we;
  logic [7:0]       arr_byte;

  assign bus_idx = addr[IDX_W-1:0];
  assign rd_idx  = (state_q == ST_ERS_VFY || state_q == ST_PGM_VFY) ? latch_idx_q : bus_idx;

  bulk_flash_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .vpp_en      (vpp_en),
    .wdata       (wdata),
    .wr_idx      (bus_idx),
    .state_q     (state_q),
    .latch_idx_q (latch_idx_q),
    .erase_all   (erase_all),
    .prog_we     (prog_we),
    .cmd_err_q   (cmd_err)
  );

  bulk_flash_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .erase_all (erase_all),
    .prog_we   (prog_we),
    .prog_idx  (bus_idx),
    .prog_data (wdata),
    .rd_idx    (rd_idx),
    .rd_byte   (arr_byte)
  );

  bulk_flash_rdmux #(
    .ADDR_W   (ADDR_W),
    .MFG_CODE (MFG_CODE),
    .DEV_CODE (DEV_CODE),
    .OPEN_BUS (OPEN_BUS)
  ) u_rdmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .state_q  (state_q),
    .addr     (addr),
    .arr_byte (arr_byte),
    .rdata_q  (rdata)
  );

  // R10: the error flag is a single-cycle pulse
  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_err && !(wr_en && vpp_en)) |=> !cmd_err);

endmodule

// File: tb/bulk_flash_ctrl_bench.sv
`timescale 1ns/1ps
module bulk_flash_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic        vpp_en = 1'b1;
  logic [7:0]  rdata;
  logic        cmd_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bulk_flash_ctrl u_bulk_flash_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .vpp_en(vpp_en),
    .rdata(rdata), .cmd_err(cmd_err)
  );

  // vector: [32] 1=read, [31:20] addr, [19:12] data, [11:4] expected (rdata or cmd_err), [3:0] requirement
  localparam int NV = 27;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 12'h000, 8'h40, 8'h00, 4'd5},   // R5 program setup
    {1'b0, 12'h005, 8'h3C, 8'h00, 4'd5},   // R5 program 0x3C at 5
    {1'b0, 12'h000, 8'hC0, 8'h00, 4'd6},   // R6 program verify
    {1'b1, 12'h020, 8'h00, 8'h3C, 4'd6},   // R6 latched byte
    {1'b0, 12'h000, 8'h00, 8'h00, 4'd9},   // R9 back to array
    {1'b1, 12'h045, 8'h00, 8'h3C, 4'd8},   // R8 0x45 folds to 5
    {1'b0, 12'h000, 8'h40, 8'h00, 4'd5},   // R5
    {1'b0, 12'h105, 8'hF0, 8'h00, 4'd8},   // R8 0x105 folds to 5
    {1'b0, 12'h000, 8'hFF, 8'h00, 4'd6},   // R6 leave program
    {1'b1, 12'h005, 8'h00, 8'h30, 4'd5},   // R5 0x3C & 0xF0
    {1'b0, 12'h000, 8'h90, 8'h00, 4'd7},   // R7
    {1'b1, 12'h000, 8'h00, 8'h89, 4'd7},   // R7 maker code
    {1'b1, 12'h001, 8'h00, 8'hB4, 4'd7},   // R7 device code
    {1'b1, 12'h002, 8'h00, 8'h00, 4'd7},   // R7 other offset
    {1'b1, 12'h040, 8'h00, 8'h00, 4'd7},   // R7 not folded
    {1'b0, 12'h000, 8'h80, 8'h00, 4'd7},   // R7 alternate code
    {1'b1, 12'h001, 8'h00, 8'hB4, 4'd7},   // R7
    {1'b0, 12'h000, 8'h20, 8'h00, 4'd3},   // R3 erase setup
    {1'b1, 12'h005, 8'h00, 8'h00, 4'd11},  // R11
    {1'b0, 12'h000, 8'h20, 8'h00, 4'd3},   // R3 erase
    {1'b1, 12'h003, 8'h00, 8'h00, 4'd11},  // R11
    {1'b0, 12'h005, 8'hA0, 8'h00, 4'd4},   // R4 latch 5
    {1'b1, 12'h007, 8'h00, 8'hFF, 4'd4},   // R4
    {1'b0, 12'h000, 8'h00, 8'h00, 4'd9},   // R9
    {1'b1, 12'h005, 8'h00, 8'hFF, 4'd3},   // R3 erased
    {1'b0, 12'h000, 8'hC0, 8'h01, 4'd10},  // R10 rejected in array mode
    {1'b1, 12'h005, 8'h00, 8'hFF, 4'd10}   // R10 still array mode
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit w, input bit r, input logic [11:0] a, input logic [7:0] d,
                      output logic [7:0] rd, output logic er);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    rd = rdata; er = cmd_err;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    logic [7:0] rd; logic er;
    xfer(1'b1, 1'b0, a, d, rd, er);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [7:0] exp);
    logic [7:0] rd; logic er;
    xfer(1'b0, 1'b1, a, 8'h00, rd, er);
    chk(req, rd, exp);
  endtask

  task automatic wr_err(input string req, input logic [11:0] a, input logic [7:0] d, input logic exp);
    logic [7:0] rd; logic er;
    xfer(1'b1, 1'b0, a, d, rd, er);
    chk(req, {7'd0, er}, {7'd0, exp});
  endtask

  initial begin
    logic [7:0] rd;
    logic er;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 cmd_err", {7'd0, cmd_err}, 8'h00);
    rd_chk("R1 array", 12'h03F, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32]) begin
        xfer(1'b0, 1'b1, VEC[i][31:20], 8'h00, rd, er);
        chk($sformatf("vector %0d R%0d", i, VEC[i][3:0]), rd, VEC[i][11:4]);
      end else begin
        xfer(1'b1, 1'b0, VEC[i][31:20], VEC[i][19:12], rd, er);
        chk($sformatf("vector %0d R%0d err", i, VEC[i][3:0]), {7'd0, er}, VEC[i][11:4]);
      end
    end

    // R10 pulse lasts one cycle
    @(negedge clk);
    chk("R10 pulse ends", {7'd0, cmd_err}, 8'h00);

    // R2 writes without program power
    vpp_en = 1'b0;
    wr_err("R2 no err", 12'h000, 8'h40, 1'b0);
    wr(12'h009, 8'h00);
    vpp_en = 1'b1;
    rd_chk("R2 unchanged", 12'h009, 8'hFF);

    // R3 erase abort keeps contents
    wr(12'h000, 8'h40); wr(12'h009, 8'h5A); wr(12'h000, 8'hFF);
    wr(12'h000, 8'h20); wr(12'h000, 8'hFF);
    rd_chk("R3 abort keeps data", 12'h009, 8'h5A);

    // R9 direct erase verify latches address
    wr(12'h009, 8'hA0);
    rd_chk("R9 direct verify", 12'h030, 8'h5A);
    wr(12'h000, 8'h90);
    rd_chk("R9 new op from verify", 12'h000, 8'h89);

    // R10 rejection in erased mode
    wr(12'h000, 8'h20); wr(12'h000, 8'h20);
    wr_err("R10 erased reject", 12'h000, 8'h55, 1'b1);
    rd_chk("R10 erased kept", 12'h000, 8'h00);
    wr(12'h002, 8'hA0);
    rd_chk("R4 verify after reject", 12'h011, 8'hFF);
    wr(12'h000, 8'h00);
    rd_chk("R3 erased earlier data", 12'h009, 8'hFF);

    // R12 read and command on the same edge
    wr(12'h000, 8'h40); wr(12'h00C, 8'h81); wr(12'h000, 8'hFF);
    xfer(1'b1, 1'b1, 12'h00C, 8'h90, rd, er);
    chk("R12 same edge pre-write", rd, 8'h81);
    rd_chk("R12 after command", 12'h000, 8'h89);
    xfer(1'b0, 1'b0, 12'h001, 8'h00, rd, er);
    chk("R12 hold", rd, 8'h89);
    wr(12'h000, 8'h00);

    // R12 read and program data on the same edge
    wr(12'h000, 8'h40);
    xfer(1'b1, 1'b1, 12'h00C, 8'h0F, rd, er);
    chk("R12 program edge open bus", rd, 8'h00);
    wr(12'h000, 8'hC0);
    rd_chk("R6 verify", 12'h000, 8'h01);

    // R6 program abort via reset, value stays programmed
    wr(12'h000, 8'h00);
    wr(12'h000, 8'h40); wr(12'h04C, 8'h00);
    rd_chk("R11 program mode", 12'h00C, 8'h00);
    wr(12'h000, 8'hFF);
    rd_chk("R6 reset to array", 12'h00C, 8'h00);
    rd_chk("R8 neighbour intact", 12'h00D, 8'hFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule